// File: doc/BRIEF.md
# Dual-Mode Forward Error Correction Codec

This block encodes and decodes short words for a radio baseband with one of two forward error correction schemes. The scheme in use is set by a single `mode` input. Every codeword is 15 bits wide.

In the triple-repetition scheme, five payload bits each occupy three adjacent codeword positions. The decoder takes a two-of-three vote in each group of three. In the (15,10) shortened cyclic Hamming scheme, ten payload bits are followed by five check bits. The decoder repairs any single flipped position. It reports a received word whose syndrome points at no single position as unrepairable.

The encoder path and the decoder path are independent. Each has a valid/ready input and a valid/ready output, with one register stage between them. Upstream logic uses the encoder before serialization and the decoder after deserialization. It reads the per-word repair flags to judge link quality.

Top module: `fec_codec`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `enc_out_valid` and `dec_out_valid` are 0.
- R2: With `mode`=0, payload bit i (i = 0..4, from `enc_in_data[4:0]`) is placed on code bits 3i, 3i+1 and 3i+2. `enc_in_data[9:5]` has no effect on the code.
- R3: With `mode`=0, `dec_out_data[i]` (i = 0..4) is the majority of code bits 3i..3i+2. `dec_out_data[9:5]` is 0 and `dec_out_uncorrectable` is 0.
- R4: With `mode`=0, `dec_out_corrected` is 1 exactly when at least one group of three disagrees.
- R5: With `mode`=1, `enc_out_code[14:5]` equals the payload. `enc_out_code[4:0]` is the remainder of payload(D)·D^5 divided by D^5+D^4+D^2+1, where code bit k is the coefficient of D^k.
- R6: With `mode`=1, a word with zero syndrome yields `dec_out_data` = code bits 14:5 and both flags 0.
- R7: With `mode`=1, a valid codeword with one flipped bit at any of the 15 positions is decoded to its original payload with `dec_out_corrected`=1 and `dec_out_uncorrectable`=0.
- R8: With `mode`=1, a nonzero syndrome that equals D^k mod g for no k gives `dec_out_uncorrectable`=1, `dec_out_corrected`=0 and the received bits 14:5 unchanged. A syndrome equal to such a D^k flips bit k and sets `dec_out_corrected`.
- R9: Each path accepts one word per cycle in which its input valid and ready are both high. A pending output holds its value while its output ready is low. Input ready is low while the output is full and not taken.
- R10: `mode` may change only when both paths are empty and no input valid is high. The first word after a legal change is coded in the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = triple repetition, 1 = shortened Hamming |
| enc_in_valid | input | 1 | Encoder payload valid |
| enc_in_ready | output | 1 | Encoder can accept a payload |
| enc_in_data | input | 10 | Payload (bits 4:0 only in repetition mode) |
| enc_out_valid | output | 1 | Codeword valid |
| enc_out_ready | input | 1 | Consumer takes the codeword |
| enc_out_code | output | 15 | Encoded word |
| dec_in_valid | input | 1 | Received word valid |
| dec_in_ready | output | 1 | Decoder can accept a word |
| dec_in_code | input | 15 | Received word |
| dec_out_valid | output | 1 | Decoded payload valid |
| dec_out_ready | input | 1 | Consumer takes the payload |
| dec_out_data | output | 10 | Decoded payload |
| dec_out_corrected | output | 1 | A repair was applied to this word |
| dec_out_uncorrectable | output | 1 | Errors detected but not repaired |

## Verification
The Hamming encoder is driven with all 1024 payloads. The decoder receives each resulting codeword clean and then with each of the 15 single flips, which separates a wrong generator from a wrong position map. A subset of payloads is also sent with every pair of flips; the expected outcome is derived from the bench's own power table of D^k mod g. That separates true unrepairable detection from a predictable miscorrection. The repetition decoder sees every pattern of the low twelve code bits, which covers every vote outcome in four groups and the flag. Stalled-output traffic and a mode change between words show that the handshake and the mode switch hold data intact.

// File: rtl/fec_pkg.sv
package fec_pkg;

    parameter int DATA_W = 10;
    parameter int PAR_W  = 5;
    parameter int CODE_W = DATA_W + PAR_W;
    parameter int REP_N  = 3;
    parameter int REP_W  = CODE_W / REP_N;
    parameter int IDX_W  = $clog2(CODE_W);

    // generator D^5+D^4+D^2+1 without its leading term
    parameter logic [PAR_W-1:0] GEN_LOW = 5'b10101;

    typedef enum logic {MODE_REP = 1'b0, MODE_HAM = 1'b1} fec_mode_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              corrected;
        logic              uncorrectable;
    } dec_result_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } err_pos_t;

    // polynomial remainder of a code word modulo the generator
    function automatic logic [PAR_W-1:0] fec_rem(input logic [CODE_W-1:0] c);
        logic [PAR_W-1:0] r;
        logic             fb;
        r = '0;
        for (int k = CODE_W - 1; k >= 0; k--) begin
            fb = r[PAR_W-1];
            r  = {r[PAR_W-2:0], c[k]};
            if (fb) r = r ^ GEN_LOW;
        end
        return r;
    endfunction

    function automatic logic [CODE_W-1:0] fec_ham_encode(input logic [DATA_W-1:0] d);
        return {d, fec_rem({d, {PAR_W{1'b0}}})};
    endfunction

    // find the single-bit position whose remainder equals the syndrome
    function automatic err_pos_t fec_err_pos(input logic [PAR_W-1:0] s);
        err_pos_t p;
        p = '0;
        for (int k = 0; k < CODE_W; k++) begin
            if (fec_rem(CODE_W'(1) << k) == s) begin
                p.hit = 1'b1;
                p.idx = IDX_W'(k);
            end
        end
        return p;
    endfunction

    function automatic logic [CODE_W-1:0] fec_rep_encode(input logic [REP_W-1:0] d);
        logic [CODE_W-1:0] c;
        for (int i = 0; i < REP_W; i++) begin
            c[REP_N*i +: REP_N] = {REP_N{d[i]}};
        end
        return c;
    endfunction

endpackage

// File: rtl/fec_encoder.sv
module fec_encoder
    import fec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fec_mode_e         mode,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CODE_W-1:0] out_code
);

    logic [CODE_W-1:0] code_next;

    assign in_ready = !out_valid || out_ready;

    always_comb begin
        if (mode == MODE_HAM) code_next = fec_ham_encode(in_data);
        else                  code_next = fec_rep_encode(in_data[REP_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_code  <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) out_code <= code_next;
        end
    end

endmodule

// File: rtl/fec_decoder.sv
module fec_decoder
    import fec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fec_mode_e         mode,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CODE_W-1:0] in_code,
    output logic              out_valid,
    input  logic              out_ready,
    output dec_result_t       out_res
);

    logic [REP_W-1:0]  vote;
    logic [REP_W-1:0]  split;
    logic [PAR_W-1:0]  syn;
    err_pos_t          pos;
    logic [CODE_W-1:0] fixed;
    dec_result_t       rep_res;
    dec_result_t       ham_res;
    dec_result_t       res_next;

    assign in_ready = !out_valid || out_ready;

    // per-group majority vote and disagreement
    for (genvar g = 0; g < REP_W; g++) begin : g_grp
        logic [REP_N-1:0] grp;
        assign grp      = in_code[REP_N*g +: REP_N];
        assign vote[g]  = (grp[0] & grp[1]) | (grp[0] & grp[2]) | (grp[1] & grp[2]);
        assign split[g] = !((&grp) || !(|grp));
    end

    assign syn = fec_rem(in_code);
    assign pos = fec_err_pos(syn);

    always_comb begin
        fixed = in_code;
        if (pos.hit) fixed[pos.idx] = !in_code[pos.idx];

        rep_res               = '0;
        rep_res.data          = DATA_W'(vote);
        rep_res.corrected     = |split;

        ham_res               = '0;
        ham_res.data          = fixed[CODE_W-1:PAR_W];
        ham_res.corrected     = pos.hit;
        ham_res.uncorrectable = (syn != '0) && !pos.hit;

        res_next = (mode == MODE_HAM) ? ham_res : rep_res;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_res   <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) out_res <= res_next;
        end
    end

endmodule

// File: rtl/fec_codec.sv
module fec_codec
    import fec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode,
    input  logic              enc_in_valid,
    output logic              enc_in_ready,
    input  logic [DATA_W-1:0] enc_in_data,
    output logic              enc_out_valid,
    input  logic              enc_out_ready,
    output logic [CODE_W-1:0] enc_out_code,
    input  logic              dec_in_valid,
    output logic              dec_in_ready,
    input  logic [CODE_W-1:0] dec_in_code,
    output logic              dec_out_valid,
    input  logic              dec_out_ready,
    output logic [DATA_W-1:0] dec_out_data,
    output logic              dec_out_corrected,
    output logic              dec_out_uncorrectable
);

    fec_mode_e   mode_e;
    dec_result_t dec_res;

    assign mode_e = fec_mode_e'(mode);

    fec_encoder u_enc (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_e),
        .in_valid  (enc_in_valid),
        .in_ready  (enc_in_ready),
        .in_data   (enc_in_data),
        .out_valid (enc_out_valid),
        .out_ready (enc_out_ready),
        .out_code  (enc_out_code)
    );

    fec_decoder u_dec (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_e),
        .in_valid  (dec_in_valid),
        .in_ready  (dec_in_ready),
        .in_code   (dec_in_code),
        .out_valid (dec_out_valid),
        .out_ready (dec_out_ready),
        .out_res   (dec_res)
    );

    assign dec_out_data          = dec_res.data;
    assign dec_out_corrected     = dec_res.corrected;
    assign dec_out_uncorrectable = dec_res.uncorrectable;

endmodule

// File: rtl/fec_codec_chk.sv
module fec_codec_chk
    import fec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mode,
    input logic              enc_in_valid,
    input logic              enc_in_ready,
    input logic              enc_out_valid,
    input logic              enc_out_ready,
    input logic [CODE_W-1:0] enc_out_code,
    input logic              dec_in_valid,
    input logic              dec_in_ready,
    input logic              dec_out_valid,
    input logic              dec_out_ready,
    input logic [DATA_W-1:0] dec_out_data,
    input logic              dec_out_corrected,
    input logic              dec_out_uncorrectable
);

    logic busy;
    assign busy = enc_in_valid || dec_in_valid || enc_out_valid || dec_out_valid;

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> !enc_out_valid && !dec_out_valid);

    // R9
    enc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        enc_out_valid && !enc_out_ready |=> enc_out_valid && $stable(enc_out_code));

    // R9
    dec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        dec_out_valid && !dec_out_ready |=> dec_out_valid && $stable(dec_out_data));

    // R9
    enc_stall_chk: assert property (@(posedge clk) disable iff (rst)
        enc_out_valid && !enc_out_ready |-> !enc_in_ready);

    // R10
    mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mode));

    // R5
    ham_code_chk: assert property (@(posedge clk) disable iff (rst)
        enc_out_valid && mode |-> fec_rem(enc_out_code) == '0);

    // R2
    rep_code_chk: assert property (@(posedge clk) disable iff (rst)
        enc_out_valid && !mode |-> enc_out_code == fec_rep_encode(enc_out_code[REP_N*(REP_W-1) +: 1] == 1'b0 ?
            {1'b0, enc_out_code[9], enc_out_code[6], enc_out_code[3], enc_out_code[0]} :
            {1'b1, enc_out_code[9], enc_out_code[6], enc_out_code[3], enc_out_code[0]}));

    // R3
    rep_never_unc_chk: assert property (@(posedge clk) disable iff (rst)
        dec_out_valid && !mode |-> !dec_out_uncorrectable && dec_out_data[DATA_W-1:REP_W] == '0);

    // R8
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        dec_out_valid |-> !(dec_out_corrected && dec_out_uncorrectable));

endmodule

bind fec_codec fec_codec_chk i_chk (
    .clk                   (clk),
    .rst                   (rst),
    .mode                  (mode),
    .enc_in_valid          (enc_in_valid),
    .enc_in_ready          (enc_in_ready),
    .enc_out_valid         (enc_out_valid),
    .enc_out_ready         (enc_out_ready),
    .enc_out_code          (enc_out_code),
    .dec_in_valid          (dec_in_valid),
    .dec_in_ready          (dec_in_ready),
    .dec_out_valid         (dec_out_valid),
    .dec_out_ready         (dec_out_ready),
    .dec_out_data          (dec_out_data),
    .dec_out_corrected     (dec_out_corrected),
    .dec_out_uncorrectable (dec_out_uncorrectable)
);

// File: tb/test_fec_codec.sv
module test_fec_codec;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode = 1'b0;
    logic        enc_in_valid = 1'b0;
    logic        enc_in_ready;
    logic [9:0]  enc_in_data = '0;
    logic        enc_out_valid;
    logic        enc_out_ready = 1'b1;
    logic [14:0] enc_out_code;
    logic        dec_in_valid = 1'b0;
    logic        dec_in_ready;
    logic [14:0] dec_in_code = '0;
    logic        dec_out_valid;
    logic        dec_out_ready = 1'b1;
    logic [9:0]  dec_out_data;
    logic        dec_out_corrected;
    logic        dec_out_uncorrectable;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [4:0] pw [15];   // D^k mod g, built by the bench

    always #4 clk = !clk;

    fec_codec i_fec_codec (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [14:0] exp_ham(input logic [9:0] d);
        logic [4:0] p;
        p = '0;
        for (int i = 0; i < 10; i++) if (d[i]) p ^= pw[i + 5];
        return {d, p};
    endfunction

    function automatic logic [4:0] exp_syn(input logic [14:0] c);
        logic [4:0] s;
        s = '0;
        for (int k = 0; k < 15; k++) if (c[k]) s ^= pw[k];
        return s;
    endfunction

    task automatic enc_one(input logic [9:0] d, output logic [14:0] q);
        @(negedge clk);
        enc_in_valid = 1'b1;
        enc_in_data  = d;
        @(negedge clk);
        enc_in_valid = 1'b0;
        q = enc_out_valid ? enc_out_code : 'x;
    endtask

    task automatic dec_one(input logic [14:0] c, output logic [11:0] r);
        @(negedge clk);
        dec_in_valid = 1'b1;
        dec_in_code  = c;
        @(negedge clk);
        dec_in_valid = 1'b0;
        r = dec_out_valid ? {dec_out_data, dec_out_corrected, dec_out_uncorrectable} : 'x;
    endtask

    task automatic drain();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 200000) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=<200000", cyc);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [14:0] q;
        logic [11:0] r;
        logic [11:0] e;

        pw[0] = 5'b00001;
        for (int k = 1; k < 15; k++) begin
            logic [5:0] t;
            t = {pw[k-1], 1'b0};
            if (t[5]) t ^= 6'b110101;
            pw[k] = t[4:0];
        end

        repeat (3) @(negedge clk);
        // R1: outputs idle during reset
        check(!enc_out_valid && !dec_out_valid, "R1 in reset", {enc_out_valid, dec_out_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!enc_out_valid && !dec_out_valid, "R1 after reset", {enc_out_valid, dec_out_valid}, 0);

        // repetition encoder, upper payload bits varied (R2)
        mode = 1'b0;
        for (int d = 0; d < 32; d++) begin
            logic [14:0] x;
            for (int i = 0; i < 5; i++) x[3*i +: 3] = {3{d[i]}};
            enc_one({5'(31 - d), 5'(d)}, q);
            check(q === x, "R2 rep encode", q, x);
        end

        // repetition decoder over all low-twelve-bit patterns (R3, R4)
        for (int p = 0; p < 4096; p++) begin
            logic [14:0] c;
            logic [9:0]  dd;
            logic        dis;
            c  = {3'(p % 7), 12'(p)};
            dd = '0;
            dis = 1'b0;
            for (int g = 0; g < 5; g++) begin
                int n;
                n = c[3*g] + c[3*g+1] + c[3*g+2];
                dd[g] = (n >= 2);
                if (n == 1 || n == 2) dis = 1'b1;
            end
            e = {dd, dis, 1'b0};
            dec_one(c, r);
            check(r[11:2] === e[11:2] && r[0] === 1'b0, "R3 rep vote", r, e);
            check(r[1] === dis, "R4 rep flag", r, e);
        end
        drain();

        // R10: mode changed while idle, next word uses Hamming
        mode = 1'b1;
        enc_one(10'h2A5, q);
        check(q === exp_ham(10'h2A5), "R10 mode switch", q, exp_ham(10'h2A5));

        for (int d = 0; d < 1024; d++) begin
            logic [14:0] x;
            x = exp_ham(10'(d));
            enc_one(10'(d), q);
            check(q === x, "R5 ham encode", q, x);
            dec_one(x, r);
            e = {10'(d), 2'b00};
            check(r === e, "R6 ham clean", r, e);
            for (int k = 0; k < 15; k++) begin
                dec_one(x ^ (15'(1) << k), r);
                e = {10'(d), 2'b10};
                check(r === e, "R7 single fix", r, e);
            end
        end

        // double flips on a payload subset (R8)
        for (int d = 0; d < 1024; d += 97) begin
            logic [14:0] x;
            x = exp_ham(10'(d));
            for (int a = 0; a < 15; a++) begin
                for (int b = a + 1; b < 15; b++) begin
                    logic [14:0] rx;
                    logic [4:0]  s;
                    int          j;
                    rx = x ^ (15'(1) << a) ^ (15'(1) << b);
                    s  = exp_syn(rx);
                    j  = -1;
                    for (int k = 0; k < 15; k++) if (pw[k] == s) j = k;
                    if (j < 0) e = {rx[14:5], 2'b01};
                    else begin
                        logic [14:0] fx;
                        fx = rx;
                        fx[j] = !fx[j];
                        e = {fx[14:5], 2'b10};
                    end
                    dec_one(rx, r);
                    check(r === e, "R8 double flip", r, e);
                end
            end
        end
        drain();

        // R9: encoder backpressure
        enc_out_ready = 1'b0;
        @(negedge clk);
        enc_in_valid = 1'b1;
        enc_in_data  = 10'h155;
        @(negedge clk);
        enc_in_data  = 10'h0F0;
        check(enc_out_valid && !enc_in_ready, "R9 stall ready", {enc_out_valid, enc_in_ready}, 2'b10);
        @(negedge clk);
        check(enc_out_code === exp_ham(10'h155), "R9 hold data", enc_out_code, exp_ham(10'h155));
        enc_out_ready = 1'b1;
        @(negedge clk);
        enc_in_valid = 1'b0;
        check(enc_out_valid && enc_out_code === exp_ham(10'h0F0), "R9 next word", enc_out_code, exp_ham(10'h0F0));
        @(negedge clk);
        check(!enc_out_valid, "R9 one per handshake", enc_out_valid, 0);

        // R9: decoder backpressure
        dec_out_ready = 1'b0;
        dec_one(exp_ham(10'h3C3) ^ 15'h0100, r);
        @(negedge clk);
        check(!dec_in_ready && dec_out_data === 10'h3C3 && dec_out_corrected, "R9 dec hold",
              {dec_in_ready, dec_out_data}, {1'b0, 10'h3C3});
        dec_out_ready = 1'b1;
        drain();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule